// File: doc/BRIEF.md
# Double-Buffered Bulk OUT Receive Buffer

This block holds the received data for one bulk OUT endpoint of a full-speed serial bus device. It has two packet slots. The packet engine delivers the bytes of a packet one per strobe, followed by an end strobe or an abort strobe. A packet that ends cleanly is committed to its slot together with its byte count, and a sticky interrupt flag is set. The protocol layer reads a single level, `ep_nak`, to decide whether the next OUT token is answered with ACK or NAK. That level is high while no whole slot is free.

On the processor side, the oldest committed packet is presented byte by byte through an 8-bit registered read port. Its length appears on `head_count`. When the last byte of the head packet is read, its slot is released. The other slot, if it holds a packet, becomes the head in the same cycle. The processor clears the interrupt with a write-one-to-clear strobe.

Packets are never split across slots. A packet longer than a slot is dropped as a whole. A packet that arrives while both slots are occupied is ignored entirely, and so is an aborted one.

Top module: `out_ep_buf`

## Requirements
- R1: After reset, `rd_data` is 0, and `irq`, `ep_nak` and `pkt_ready` are low, and `head_count` is 0.
- R2: A committed packet of 1 to 64 bytes is returned byte for byte in the order received. `head_count` shows its length while `pkt_ready` is high, and `head_count` is 0 while `pkt_ready` is low.
- R3: `irq` goes high in the cycle after the end strobe of a committed packet and stays high until `irq_clr` is pulsed. If a commit and `irq_clr` fall in the same cycle, the commit wins.
- R4: Two committed packets are stored at once and are read in arrival order.
- R5: `ep_nak` is high exactly while both slots hold a packet. It falls in the cycle after the last byte of the head packet is read.
- R6: Reading the last byte of the head packet releases its slot. A waiting packet is then presented at once, with its own length, and no idle read is needed.
- R7: A read while `pkt_ready` is low returns 0 in the following cycle and changes no state.
- R8: A packet ended by `rx_abort` leaves no trace: no interrupt, no slot used, and later packets are stored normally.
- R9: A packet of more than 64 bytes is dropped at its end strobe. `rx_overrun` is high during that end strobe, no interrupt is raised, and the slot stays free.
- R10: A packet whose first byte arrives while both slots are full is ignored. Both stored packets remain intact and no interrupt is raised.
- R11: An end strobe with no preceding byte commits nothing and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One received byte on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | Clean end of the current packet |
| rx_abort | input | 1 | Current packet aborted |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| rd_en | input | 1 | Processor read strobe for one byte |
| rx_overrun | output | 1 | High during the end strobe of a packet dropped for length |
| ep_nak | output | 1 | Answer the next OUT token with NAK |
| rd_data | output | 8 | Byte returned by the last read |
| head_count | output | 7 | Byte count of the head packet, 0 if none |
| pkt_ready | output | 1 | A committed packet is at the head |
| irq | output | 1 | Sticky packet-received flag |

## Verification
Single packets of every length from 1 to 64 bytes are sent and read back. Each byte carries a value derived from its length and position, so a wrong address, a wrong count or an off-by-one release gives a different byte or length. Pairs of packets with differing short, medium and full lengths show whether the head switches in the right order and whether the NAK level follows slot occupancy rather than byte counts. Aborted packets, packets of 65 and 70 bytes, a packet sent into two full slots and a bare end strobe are each followed by reads and a fresh packet. This shows that nothing leaked into storage or the interrupt.

// File: rtl/out_ep_pkg.sv
// Shared types for the bulk OUT receive buffer.
package out_ep_pkg;
    // Receive side: waiting for a packet, filling a slot, or skipping a packet that has no room.
    typedef enum logic [1:0] {RX_IDLE, RX_FILL, RX_SKIP} rx_state_e;
endpackage

// File: rtl/out_ep_mem.sv
// Two packet slots of SLOT_BYTES bytes each, with one write port and one
// asynchronous read port. The contents are not reset; the bookkeeping in the
// top module decides which bytes are valid.
module out_ep_mem #(
    parameter int SLOT_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int AW        = $clog2(SLOT_BYTES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_slot,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_slot,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_byte
);
    logic [DATA_W-1:0] bank_q [2];

    for (genvar s = 0; s < 2; s++) begin : g_slot
        logic [DATA_W-1:0] mem [SLOT_BYTES];
        // Store the incoming byte when this slot is the write target.
        always_ff @(posedge clk) begin
            if (wr_en && int'(wr_slot) == s) mem[wr_addr] <= wr_data;
        end
        assign bank_q[s] = mem[rd_addr];
    end

    assign rd_byte = bank_q[rd_slot];
endmodule

// File: rtl/out_ep_rxctl.sv
// Receive-side control. A slot is claimed on the first byte of a packet if
// one is free. Bytes are then counted. At the clean end strobe the packet is
// committed, or it is dropped if it overran the slot. Assumes rx_valid,
// rx_eop and rx_abort are never high in the same cycle.
module out_ep_rxctl
    import out_ep_pkg::*;
#(
    parameter int SLOT_BYTES = 64,
    localparam int AW        = $clog2(SLOT_BYTES),
    localparam int CW        = $clog2(SLOT_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_eop,
    input  logic          rx_abort,
    input  logic [1:0]    slot_full,
    input  logic          head,
    output logic          wr_en,
    output logic          wr_slot,
    output logic [AW-1:0] wr_addr,
    output logic          commit,
    output logic [CW-1:0] commit_cnt,
    output logic          overrun
);
    rx_state_e     st_q;
    logic          slot_q;
    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic          any_free;
    logic          pick;
    logic          at_limit;

    assign any_free = ~(&slot_full);
    // If the head is empty both slots are empty, so the head is the oldest-to-be.
    assign pick     = slot_full[head] ? ~head : head;
    assign at_limit = (cnt_q == CW'(SLOT_BYTES));

    // Write strobe, slot and address for the byte on the input.
    always_comb begin
        wr_en   = rx_valid && (((st_q == RX_IDLE) && any_free) ||
                               ((st_q == RX_FILL) && !at_limit));
        wr_slot = (st_q == RX_IDLE) ? pick : slot_q;
        wr_addr = (st_q == RX_IDLE) ? '0 : cnt_q[AW-1:0];
    end

    assign commit     = (st_q == RX_FILL) && rx_eop && !ovf_q;
    assign overrun    = (st_q == RX_FILL) && rx_eop && ovf_q;
    assign commit_cnt = cnt_q;

    // Packet-level state: claim, count, flag overrun, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_IDLE;
            slot_q <= 1'b0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            case (st_q)
                RX_IDLE: if (rx_valid) begin
                    if (any_free) begin
                        st_q   <= RX_FILL;
                        slot_q <= pick;
                        cnt_q  <= CW'(1);
                        ovf_q  <= 1'b0;
                    end else begin
                        st_q <= RX_SKIP;
                    end
                end
                RX_FILL: begin
                    if (rx_eop || rx_abort) st_q <= RX_IDLE;
                    else if (rx_valid) begin
                        if (at_limit) ovf_q <= 1'b1;
                        else          cnt_q <= cnt_q + CW'(1);
                    end
                end
                RX_SKIP: if (rx_eop || rx_abort) st_q <= RX_IDLE;
                default: st_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/out_ep_rdctl.sv
// Processor read side. Each read strobe returns the next byte of the head
// packet, or zero when no packet is present. The last byte raises a release
// pulse for the head slot. Assumes head_cnt is non-zero whenever head_full is high.
module out_ep_rdctl #(
    parameter int SLOT_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int AW        = $clog2(SLOT_BYTES),
    localparam int CW        = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              head_full,
    input  logic [CW-1:0]     head_cnt,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [AW-1:0]     rd_addr,
    output logic              release_o,
    output logic [DATA_W-1:0] rd_data
);
    logic [AW-1:0] rptr_q;
    logic          take;

    assign take      = rd_en && head_full;
    assign release_o = take && (CW'(rptr_q) + CW'(1) == head_cnt);
    assign rd_addr   = rptr_q;

    // Return a byte, or zero when empty, and step through the head packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q  <= '0;
            rd_data <= '0;
        end else begin
            if (rd_en) rd_data <= head_full ? rd_byte : '0;
            if (take)  rptr_q  <= release_o ? '0 : rptr_q + AW'(1);
        end
    end
endmodule

// File: rtl/out_ep_buf.sv
// Double-buffered bulk OUT endpoint receive buffer. Tracks which slot is full,
// the byte count of each slot and the head (oldest) slot. Derives the NAK
// level and keeps the sticky interrupt. Invariant: if the head slot is empty,
// the other slot is empty too.
module out_ep_buf #(
    parameter int SLOT_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int AW        = $clog2(SLOT_BYTES),
    localparam int CW        = $clog2(SLOT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_eop,
    input  logic              rx_abort,
    input  logic              irq_clr,
    input  logic              rd_en,
    output logic              rx_overrun,
    output logic              ep_nak,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     head_count,
    output logic              pkt_ready,
    output logic              irq
);
    logic [1:0]        full_q, full_nx;
    logic [CW-1:0]     cnt_q [2];
    logic              head_q;
    logic              irq_q;
    logic              wr_en, wr_slot, commit, release_w;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [CW-1:0]     commit_cnt;
    logic [DATA_W-1:0] rd_byte;

    out_ep_rxctl #(.SLOT_BYTES(SLOT_BYTES)) i_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eop(rx_eop),
        .rx_abort(rx_abort), .slot_full(full_q), .head(head_q),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr),
        .commit(commit), .commit_cnt(commit_cnt), .overrun(rx_overrun)
    );

    out_ep_mem #(.SLOT_BYTES(SLOT_BYTES), .DATA_W(DATA_W)) i_mem (
        .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr),
        .wr_data(rx_data), .rd_slot(head_q), .rd_addr(rd_addr), .rd_byte(rd_byte)
    );

    out_ep_rdctl #(.SLOT_BYTES(SLOT_BYTES), .DATA_W(DATA_W)) i_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .head_full(full_q[head_q]),
        .head_cnt(cnt_q[head_q]), .rd_byte(rd_byte), .rd_addr(rd_addr),
        .release_o(release_w), .rd_data(rd_data)
    );

    // Next slot occupancy: release of the head and commit of the written slot.
    always_comb begin
        full_nx = full_q;
        if (release_w) full_nx[head_q]  = 1'b0;
        if (commit)    full_nx[wr_slot] = 1'b1;
    end

    // Slot flags, byte counts and head pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
            head_q <= 1'b0;
            for (int s = 0; s < 2; s++) cnt_q[s] <= '0;
        end else begin
            full_q <= full_nx;
            if (commit)    cnt_q[wr_slot] <= commit_cnt;
            if (release_w) head_q <= ~head_q;
        end
    end

    // Sticky interrupt; a new packet wins over the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (commit)  irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
    end

    assign pkt_ready  = full_q[head_q];
    assign head_count = pkt_ready ? cnt_q[head_q] : '0;
    assign ep_nak     = &full_q;
    assign irq        = irq_q;
endmodule

// File: rtl/out_ep_chk.sv
// Assertion checker for out_ep_buf. It observes the top-level ports only and
// is attached by the bind at the end of this file.
module out_ep_chk #(
    parameter int SLOT_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int CW        = $clog2(SLOT_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_eop,
    input logic              rx_abort,
    input logic              irq_clr,
    input logic              rd_en,
    input logic              rx_overrun,
    input logic              ep_nak,
    input logic [DATA_W-1:0] rd_data,
    input logic [CW-1:0]     head_count,
    input logic              pkt_ready,
    input logic              irq
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (rd_data == '0 && !irq && !pkt_ready && !ep_nak)); // R1
    AST_COUNT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !pkt_ready |-> head_count == '0); // R2
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pkt_ready |-> (head_count != '0 && head_count <= CW'(SLOT_BYTES))); // R2
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq && !irq_clr) |=> irq); // R3
    AST_NAK_HEAD: assert property (@(posedge clk) disable iff (!rst_n) ep_nak |-> pkt_ready); // R5
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !pkt_ready) |=> rd_data == '0); // R7
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (rx_abort && !rx_eop && !irq) |=> !irq); // R8
    AST_OVERRUN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (rx_overrun && !irq) |=> !irq); // R9
endmodule

bind out_ep_buf out_ep_chk #(.SLOT_BYTES(SLOT_BYTES), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_out_ep_buf.sv
`timescale 1ns/1ps
module test_out_ep_buf;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rx_valid = 1'b0, rx_eop = 1'b0, rx_abort = 1'b0, irq_clr = 1'b0, rd_en = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_overrun, ep_nak, pkt_ready, irq;
    logic [7:0] rd_data;
    logic [6:0] head_count;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    out_ep_buf i_out_ep_buf (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eop(rx_eop), .rx_abort(rx_abort), .irq_clr(irq_clr), .rd_en(rd_en),
        .rx_overrun(rx_overrun), .ep_nak(ep_nak), .rd_data(rd_data),
        .head_count(head_count), .pkt_ready(pkt_ready), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(int seed, int i);
        return 8'(seed * 31 + i * 13 + 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Send len bytes, then end (kind 0) or abort (kind 1); ovr returns rx_overrun in the end cycle.
    task automatic send_pkt(int len, int seed, int kind, bit clr, output bit ovr);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1; rx_data = pat(seed, i);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        if (kind == 0) rx_eop = 1'b1; else rx_abort = 1'b1;
        irq_clr = clr;
        #1 ovr = rx_overrun;
        @(negedge clk);
        rx_eop = 1'b0; rx_abort = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic read_pkt(int len, int seed, string req);
        for (int i = 0; i < len; i++) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            chk(req, int'(rd_data), int'(pat(seed, i)));
        end
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R3 clear", int'(irq), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        bit ovr;
        int la[3] = '{1, 17, 64};
        int lb[3] = '{1, 33, 64};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", int'(rd_data), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 nak", int'(ep_nak), 0);
        chk("R1 ready", int'(pkt_ready), 0);
        chk("R1 count", int'(head_count), 0);

        // R7 read with no packet
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        chk("R7 data", int'(rd_data), 0);
        chk("R7 ready", int'(pkt_ready), 0);

        // R2 R3 sweep of every length
        for (int len = 1; len <= 64; len++) begin
            send_pkt(len, len, 0, 1'b0, ovr);
            chk("R3 irq set", int'(irq), 1);
            chk("R2 count", int'(head_count), len);
            chk("R5 nak one slot", int'(ep_nak), 0);
            read_pkt(len, len, "R2 data");
            chk("R6 released", int'(pkt_ready), 0);
            chk("R3 sticky", int'(irq), 1);
            clear_irq();
            rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
            chk("R7 past end", int'(rd_data), 0);
        end

        // R4 R5 R6 packet pairs
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                send_pkt(la[a], 100 + a, 0, 1'b0, ovr);
                chk("R5 nak one", int'(ep_nak), 0);
                send_pkt(lb[b], 200 + b, 0, 1'b0, ovr);
                chk("R5 nak both", int'(ep_nak), 1);
                chk("R4 head first", int'(head_count), la[a]);
                read_pkt(la[a], 100 + a, "R4 first data");
                chk("R5 nak drop", int'(ep_nak), 0);
                chk("R6 ready", int'(pkt_ready), 1);
                chk("R6 count", int'(head_count), lb[b]);
                read_pkt(lb[b], 200 + b, "R4 second data");
                chk("R6 empty", int'(pkt_ready), 0);
                clear_irq();
            end
        end

        // R10 packet into two full slots
        send_pkt(20, 7, 0, 1'b0, ovr);
        send_pkt(30, 8, 0, 1'b0, ovr);
        clear_irq();
        send_pkt(9, 99, 0, 1'b0, ovr);
        chk("R10 irq", int'(irq), 0);
        chk("R10 count", int'(head_count), 20);
        read_pkt(20, 7, "R10 first");
        chk("R10 count2", int'(head_count), 30);
        read_pkt(30, 8, "R10 second");
        chk("R10 empty", int'(pkt_ready), 0);

        // R8 abort
        send_pkt(10, 55, 1, 1'b0, ovr);
        chk("R8 irq", int'(irq), 0);
        chk("R8 ready", int'(pkt_ready), 0);
        send_pkt(5, 56, 0, 1'b0, ovr);
        chk("R8 next count", int'(head_count), 5);
        read_pkt(5, 56, "R8 next data");
        clear_irq();

        // R9 overlong packets
        send_pkt(65, 60, 0, 1'b0, ovr);
        chk("R9 overrun 65", int'(ovr), 1);
        chk("R9 irq", int'(irq), 0);
        chk("R9 ready", int'(pkt_ready), 0);
        send_pkt(70, 61, 0, 1'b0, ovr);
        chk("R9 overrun 70", int'(ovr), 1);
        chk("R9 irq 70", int'(irq), 0);
        send_pkt(64, 62, 0, 1'b0, ovr);
        chk("R9 no overrun 64", int'(ovr), 0);
        chk("R9 count 64", int'(head_count), 64);
        read_pkt(64, 62, "R9 data 64");
        clear_irq();

        // R11 bare end strobe
        send_pkt(0, 0, 0, 1'b0, ovr);
        chk("R11 irq", int'(irq), 0);
        chk("R11 ready", int'(pkt_ready), 0);

        // R3 commit wins over clear in the same cycle
        send_pkt(3, 77, 0, 1'b1, ovr);
        chk("R3 set wins", int'(irq), 1);
        read_pkt(3, 77, "R3 data");
        clear_irq();

        report();
    end
endmodule